// File: doc/BRIEF.md
# Load Speculation Replay Tracker

This block sits next to the scheduler of an out-of-order core. A load that is expected to hit the data cache gets its dependents woken on a fixed timer, before the cache has said whether it hit. The tracker keeps a short record of every instruction scheduled since each load. When the cache outcome arrives it decides what happens next. If a speculated load hit, nothing further is needed. If it missed, every instruction scheduled inside that load's window is sent back for rescheduling, whether or not it depends on the load. The missing load's dependents are woken again only when the line is filled.

Some loads are scheduled without speculation: those predicted to miss, and all loads issued while speculation is switched off. For these loads the dependents wait for the real outcome. Such a load never causes a cancel. Recovery is deliberately coarse. It is driven by scheduling order alone, so the tracker needs no dependence information.

Timing is counted in clock edges. An instruction is "issued at edge n" when the issue port carries it at rising edge n. A registered output "at edge m" is high during the cycle that follows edge m.

Top module: `ld_spec_replay`

## Requirements
- R1: During and right after a synchronous active-high reset, every wake output and the replay output are low.
- R2: A speculated load pulses `wake_spec_valid` with its tag for one cycle at edge n+3, where n is its issue edge. A speculated load is one with `iss_is_load`=1 and `iss_pred_hit`=1, issued while `spec_off`=0.
- R3: An outcome is accepted only when it arrives at edge n+5 and `res_tag` equals the tag of the load issued at edge n. Any other outcome, including one for a non-load or one with a wrong tag, has no effect on any output.
- R4: When a speculated load hits, no replay starts and no further wake is produced for it.
- R5: When a speculated load misses, the replay output lists the tags of the valid instructions issued at edges n+1 to n+4. They come out oldest first, one per cycle, at edges n+5, n+6 and so on, with idle issue slots skipped. The instruction issued at edge n+5 and the load itself are not replayed.
- R6: A held load is a load issued with `iss_pred_hit`=0 or with `spec_off`=1. A held load gets no timer wake and never starts a replay. If its outcome is a hit, `wake_res_valid` pulses with its tag at edge n+5.
- R7: A load whose accepted outcome is a miss, held or speculated, becomes pending. A `fill_valid` pulse carrying a pending tag produces one `wake_fill_valid` pulse with that tag one edge later and clears the pending entry. A fill for a tag that is not pending has no effect.
- R8: An instruction that has been replayed leaves the record. If it is a speculated load whose timer wake falls on the cancelling edge or later, that wake is dropped. Its own later outcome is ignored, so no tag is ever replayed twice.
- R9: Reset empties the record, any replay in progress and the pending-fill entries. An outcome or fill referring to a load from before the reset has no effect.
- R10: An instruction with `iss_is_load`=0 never produces any wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| spec_off | input | 1 | When 1, loads issued now are held instead of speculated |
| iss_valid | input | 1 | An instruction is scheduled this cycle |
| iss_tag | input | TAG_W | Tag of the scheduled instruction |
| iss_is_load | input | 1 | Scheduled instruction is a load |
| iss_pred_hit | input | 1 | Hit prediction for a scheduled load |
| res_valid | input | 1 | A cache outcome is presented |
| res_tag | input | TAG_W | Load tag of the outcome |
| res_hit | input | 1 | Outcome: 1 hit, 0 miss |
| fill_valid | input | 1 | Fill-return pulse |
| fill_tag | input | TAG_W | Load tag of the returned fill |
| wake_spec_valid | output | 1 | Timer wake for a speculated load |
| wake_spec_tag | output | TAG_W | Load tag of the timer wake |
| wake_res_valid | output | 1 | Outcome wake for a held load that hit |
| wake_res_tag | output | TAG_W | Load tag of the outcome wake |
| wake_fill_valid | output | 1 | Wake after fill for a load that missed |
| wake_fill_tag | output | TAG_W | Load tag of the fill wake |
| replay_busy | output | 1 | A tag to reschedule is on `replay_tag` |
| replay_tag | output | TAG_W | Tag being sent back for rescheduling |

## Verification
A corrupted history slot shows up at the replay port within five edges. A tag goes missing, appears twice or appears out of order in the drain that follows a speculated miss. A timer wake that should have been suppressed would also fire for a load that was already cancelled. A wrong pending-fill entry shows up at the fill port: a legitimate fill produces no wake, or a stale fill produces a wake it should not. The reference model in the bench tracks every instruction by its issue edge. It compares all four output groups on every cycle, so a divergence is reported at the first edge where it reaches a port.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_PLAIN = 2'd1,
    K_SPEC  = 2'd2,
    K_HELD  = 2'd3
  } kind_e;

  // Sort an issued instruction into its tracking class.
  function automatic kind_e classify(input logic is_ld, input logic pred_hit,
                                     input logic spec_off);
    if (!is_ld) return K_PLAIN;
    if (pred_hit && !spec_off) return K_SPEC;
    return K_HELD;
  endfunction
endpackage

// File: rtl/lsr_history.sv
module lsr_history #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld,
  input  logic [TAG_W-1:0]            in_tag,
  input  logic [1:0]                  in_kind,
  input  logic                        kill,
  output logic [DEPTH-1:0]            h_vld,
  output logic [DEPTH-1:0][TAG_W-1:0] h_tag,
  output logic [DEPTH-1:0][1:0]       h_kind
);
  // Slot k holds the instruction issued k+1 edges ago; kill drops every
  // entry that moves into slots 1..DEPTH-1 on this edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      h_vld  <= '0;
      h_tag  <= '0;
      h_kind <= '0;
    end else begin
      h_vld[0]  <= in_vld;
      h_tag[0]  <= in_tag;
      h_kind[0] <= in_kind;
      for (int k = 1; k < DEPTH; k++) begin
        h_vld[k]  <= h_vld[k-1] && !kill;
        h_tag[k]  <= h_tag[k-1];
        h_kind[k] <= h_kind[k-1];
      end
    end
  end
endmodule

// File: rtl/lsr_replay.sv
module lsr_replay #(
  parameter int TAG_W = 6,
  parameter int N     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [N-1:0]            in_vld,
  input  logic [N-1:0][TAG_W-1:0] in_tag,
  output logic                    busy,
  output logic [TAG_W-1:0]        tag
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0][TAG_W-1:0] q;
  logic [CW-1:0]           cnt;

  // Compact valid tags, index N-1 (oldest) first, into q[0], q[1], ...
  function automatic logic [N-1:0][TAG_W-1:0] pack_tags(
      input logic [N-1:0] v, input logic [N-1:0][TAG_W-1:0] t);
    logic [N-1:0][TAG_W-1:0] o;
    int j;
    o = '0;
    j = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) begin
        o[j] = t[i];
        j++;
      end
    end
    return o;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      cnt <= '0;
    end else if (load) begin
      q   <= pack_tags(in_vld, in_tag);
      cnt <= CW'($countones(in_vld));
    end else if (cnt != '0) begin
      for (int i = 0; i < N - 1; i++) q[i] <= q[i+1];
      q[N-1] <= '0;
      cnt    <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
  assign tag  = q[0];

  // R5
  always_comb begin
    cnt_bound_chk: assert (rst || cnt <= CW'(N));
  end
endmodule

// File: rtl/lsr_fill.sv
module lsr_fill #(
  parameter int TAG_W = 6,
  parameter int NPEND = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             fill_v,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             wake_v,
  output logic [TAG_W-1:0] wake_tag,
  output logic             full
);
  localparam int IW = (NPEND > 1) ? $clog2(NPEND) : 1;

  logic [NPEND-1:0]            pv;
  logic [NPEND-1:0][TAG_W-1:0] ptag;
  logic [NPEND-1:0]            hitv;
  logic [IW-1:0]               free_idx;

  function automatic logic [IW-1:0] first_free(input logic [NPEND-1:0] v);
    logic [IW-1:0] idx;
    idx = '0;
    for (int i = NPEND - 1; i >= 0; i--) if (!v[i]) idx = i[IW-1:0];
    return idx;
  endfunction

  always_comb begin
    for (int i = 0; i < NPEND; i++) hitv[i] = fill_v && pv[i] && (ptag[i] == fill_tag);
  end

  assign free_idx = first_free(pv);
  assign full     = &pv;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv       <= '0;
      ptag     <= '0;
      wake_v   <= 1'b0;
      wake_tag <= '0;
    end else begin
      wake_v   <= |hitv;
      wake_tag <= fill_tag;
      for (int i = 0; i < NPEND; i++) if (hitv[i]) pv[i] <= 1'b0;
      if (alloc && !full) begin
        pv[free_idx]   <= 1'b1;
        ptag[free_idx] <= alloc_tag;
      end
    end
  end
endmodule

// File: rtl/ld_spec_replay.sv
module ld_spec_replay #(
  parameter int TAG_W    = 6,
  parameter int RES_LAT  = 5,
  parameter int WAKE_LAT = 3,
  parameter int NPEND    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spec_off,
  input  logic             iss_valid,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic             iss_is_load,
  input  logic             iss_pred_hit,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_hit,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             wake_spec_valid,
  output logic [TAG_W-1:0] wake_spec_tag,
  output logic             wake_res_valid,
  output logic [TAG_W-1:0] wake_res_tag,
  output logic             wake_fill_valid,
  output logic [TAG_W-1:0] wake_fill_tag,
  output logic             replay_busy,
  output logic [TAG_W-1:0] replay_tag
);
  import lsr_pkg::*;

  localparam int OLD = RES_LAT - 1;   // slot of the load whose outcome is due
  localparam int WIN = RES_LAT - 1;   // younger slots inside its window
  localparam int TMR = WAKE_LAT - 1;  // slot whose timer wake is due

  logic [1:0]                   kind_in;
  logic [RES_LAT-1:0]           h_vld;
  logic [RES_LAT-1:0][TAG_W-1:0] h_tag;
  logic [RES_LAT-1:0][1:0]      h_kind;

  // Named events for assertions and clarity.
  logic res_match, spec_miss, spec_hit, held_hit, to_pend, timer_due, pend_full;

  assign kind_in = classify(iss_is_load, iss_pred_hit, spec_off);

  lsr_history #(.TAG_W(TAG_W), .DEPTH(RES_LAT)) u_hist (
    .clk(clk), .rst(rst), .in_vld(iss_valid), .in_tag(iss_tag),
    .in_kind(kind_in), .kill(spec_miss),
    .h_vld(h_vld), .h_tag(h_tag), .h_kind(h_kind)
  );

  assign res_match = res_valid && h_vld[OLD] && (h_kind[OLD] != K_PLAIN)
                     && (h_tag[OLD] == res_tag);
  assign spec_miss = res_match && (h_kind[OLD] == K_SPEC) && !res_hit;
  assign spec_hit  = res_match && (h_kind[OLD] == K_SPEC) && res_hit;
  assign held_hit  = res_match && (h_kind[OLD] == K_HELD) && res_hit;
  assign to_pend   = res_match && !res_hit;
  assign timer_due = h_vld[TMR] && (h_kind[TMR] == K_SPEC) && !spec_miss;

  lsr_replay #(.TAG_W(TAG_W), .N(WIN)) u_replay (
    .clk(clk), .rst(rst), .load(spec_miss),
    .in_vld(h_vld[WIN-1:0]), .in_tag(h_tag[WIN-1:0]),
    .busy(replay_busy), .tag(replay_tag)
  );

  lsr_fill #(.TAG_W(TAG_W), .NPEND(NPEND)) u_fill (
    .clk(clk), .rst(rst), .alloc(to_pend), .alloc_tag(h_tag[OLD]),
    .fill_v(fill_valid), .fill_tag(fill_tag),
    .wake_v(wake_fill_valid), .wake_tag(wake_fill_tag), .full(pend_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_spec_valid <= 1'b0;
      wake_spec_tag   <= '0;
      wake_res_valid  <= 1'b0;
      wake_res_tag    <= '0;
    end else begin
      wake_spec_valid <= timer_due;
      wake_spec_tag   <= h_tag[TMR];
      wake_res_valid  <= held_hit;
      wake_res_tag    <= h_tag[OLD];
    end
  end

  // R8
  replay_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    spec_miss |-> !replay_busy);
  // R4
  spec_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    spec_hit |=> !$rose(replay_busy));
  // R6
  held_no_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (res_match && (h_kind[OLD] == K_HELD)) |=> !$rose(replay_busy));
  // R2
  timer_kind_chk: assert property (@(posedge clk) disable iff (rst)
    wake_spec_valid |-> ($past(h_kind[TMR]) == K_SPEC));
  // R6
  res_wake_src_chk: assert property (@(posedge clk) disable iff (rst)
    wake_res_valid |-> (($past(h_kind[OLD]) == K_HELD) && $past(res_hit)));
  // R7
  pend_room_chk: assert property (@(posedge clk) disable iff (rst)
    to_pend |-> !pend_full);
endmodule

// File: tb/test_ld_spec_replay.sv
module test_ld_spec_replay;
  localparam int MAXC = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spec_off = 1'b0;
  logic iss_valid = 1'b0, iss_is_load = 1'b0, iss_pred_hit = 1'b0;
  logic [5:0] iss_tag = '0;
  logic res_valid = 1'b0, res_hit = 1'b0;
  logic [5:0] res_tag = '0;
  logic fill_valid = 1'b0;
  logic [5:0] fill_tag = '0;
  logic wsv, wrv, wfv, rpb;
  logic [5:0] wst, wrt, wft, rpt;

  ld_spec_replay i_ld_spec_replay (
    .clk(clk), .rst(rst), .spec_off(spec_off),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_is_load(iss_is_load),
    .iss_pred_hit(iss_pred_hit), .res_valid(res_valid), .res_tag(res_tag),
    .res_hit(res_hit), .fill_valid(fill_valid), .fill_tag(fill_tag),
    .wake_spec_valid(wsv), .wake_spec_tag(wst),
    .wake_res_valid(wrv), .wake_res_tag(wrt),
    .wake_fill_valid(wfv), .wake_fill_tag(wft),
    .replay_busy(rpb), .replay_tag(rpt)
  );

  always #2 clk = ~clk;

  // Reference model: every instruction is kept by its issue edge.
  int  n = 16;
  bit  iv[MAXC];
  int  itag[MAXC];
  int  ik[MAXC];        // 1 plain, 2 speculated load, 3 held load
  bit  killed[MAXC];
  bit  plan[MAXC];
  int  rep_q[$];
  int  pend_q[$];
  bit  e_sv, e_rv, e_fv, e_rp;
  int  e_st, e_rt, e_ft, e_rpt;
  bit  iss_plan = 1'b0;
  bit  started = 1'b0;
  int  checks = 0, errors = 0;
  string phase = "R1 reset";
  bit  auto_res = 1'b1, auto_fill = 1'b1, man_res = 1'b0, man_fill = 1'b0;
  bit  done = 1'b0;

  always @(posedge clk) begin
    int c0, c3;
    bit match, found;
    n = n + 1;
    started = 1'b1;
    if (rst) begin
      for (int c = n - 8; c <= n; c++) iv[c] = 1'b0;
      rep_q.delete();
      pend_q.delete();
      {e_sv, e_rv, e_fv, e_rp} = '0;
    end else begin
      iv[n]     = iss_valid;
      itag[n]   = iss_tag;
      ik[n]     = !iss_is_load ? 1 : ((iss_pred_hit && !spec_off) ? 2 : 3);
      killed[n] = 1'b0;
      plan[n]   = iss_plan;
      if (rep_q.size() > 0) void'(rep_q.pop_front());
      // fill lookup happens before this edge's new pending entry
      e_fv = 1'b0;
      found = 1'b0;
      if (fill_valid) begin
        for (int i = 0; i < pend_q.size(); i++) begin
          if (!found && pend_q[i] == fill_tag) begin
            found = 1'b1;
            pend_q.delete(i);
          end
        end
        e_fv = found;
        e_ft = fill_tag;
      end
      c0 = n - 5;
      match = res_valid && iv[c0] && !killed[c0] && ik[c0] != 1 && itag[c0] == res_tag;
      e_rv = match && ik[c0] == 3 && res_hit;
      e_rt = itag[c0];
      if (match && !res_hit) begin
        pend_q.push_back(itag[c0]);
        if (ik[c0] == 2) begin
          for (int c = n - 4; c <= n - 1; c++) begin
            if (iv[c] && !killed[c]) begin
              rep_q.push_back(itag[c]);
              killed[c] = 1'b1;
            end
          end
        end
      end
      c3 = n - 3;
      e_sv = iv[c3] && ik[c3] == 2 && !killed[c3];
      e_st = itag[c3];
      e_rp = rep_q.size() > 0;
      e_rpt = e_rp ? rep_q[0] : 0;
    end
  end

  task automatic chk(input string lbl, input bit av, input int at, input bit ev, input int et);
    checks++;
    if (av !== ev || (ev && at != et)) begin
      errors++;
      $display("FAIL %s (%s): actual v=%0d tag=%0d expected v=%0d tag=%0d at edge %0d",
               lbl, phase, av, at, ev, et, n);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R2 R8 timer wake", wsv, wst, e_sv, e_st);
      chk("R6 outcome wake", wrv, wrt, e_rv, e_rt);
      chk("R7 fill wake", wfv, wft, e_fv, e_ft);
      chk("R5 R8 replay", rpb, rpt, e_rp, e_rpt);
    end
  end

  task automatic tick();
    int c;
    c = n - 4;
    if (!man_res) begin
      res_valid = 1'b0;
      if (auto_res && iv[c] && ik[c] != 1) begin
        res_valid = 1'b1;
        res_tag   = itag[c][5:0];
        res_hit   = plan[c];
      end
    end
    if (!man_fill) begin
      fill_valid = 1'b0;
      if (auto_fill && pend_q.size() > 0) begin
        fill_valid = 1'b1;
        fill_tag   = pend_q[0][5:0];
      end
    end
    @(posedge clk);
    @(negedge clk);
    iss_valid = 1'b0;
    man_res   = 1'b0;
    man_fill  = 1'b0;
    res_valid = 1'b0;
    fill_valid = 1'b0;
  endtask

  task automatic issue(input int t, input bit ld, input bit ph, input bit hit);
    iss_valid    = 1'b1;
    iss_tag      = t[5:0];
    iss_is_load  = ld;
    iss_pred_hit = ph;
    iss_plan     = hit;
    tick();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int tg;
    // R1: quiet outputs during and after reset
    @(negedge clk);
    idle(3);
    checks++;
    if ({wsv, wrv, wfv, rpb} !== 4'b0) begin
      errors++;
      $display("FAIL R1: actual %b expected 0000", {wsv, wrv, wfv, rpb});
    end
    rst = 1'b0;
    idle(2);

    // R2 R4 R10: speculated load that hits, plain ops around it
    phase = "R4 hit keeps going";
    issue(1, 0, 0, 0); issue(2, 1, 1, 1); issue(3, 0, 0, 0);
    issue(4, 0, 1, 0); idle(8);

    // R5: speculated miss, window with a gap, issue at outcome edge kept
    phase = "R5 miss replay";
    auto_fill = 1'b0;
    issue(10, 1, 1, 0); issue(11, 0, 0, 0); idle(1); issue(12, 0, 0, 0);
    issue(13, 1, 0, 1); issue(14, 0, 0, 0); idle(6);
    // R7: a fill for a tag that is not pending does nothing
    phase = "R7 stray fill";
    man_fill = 1'b1; fill_valid = 1'b1; fill_tag = 6'd33; tick();
    man_fill = 1'b1; fill_valid = 1'b1; fill_tag = 6'd10; tick();
    idle(2);
    auto_fill = 1'b1;

    // R6: held loads (speculation off, and predicted miss)
    phase = "R6 held loads";
    spec_off = 1'b1;
    issue(20, 1, 1, 1); issue(21, 0, 0, 0);
    spec_off = 1'b0;
    issue(22, 1, 0, 0); issue(23, 0, 0, 0); idle(9);

    // R8: younger speculated load cancelled on its timer-wake edge
    phase = "R8 cancel younger load";
    issue(30, 1, 1, 0); issue(31, 0, 0, 0); issue(32, 1, 1, 0);
    issue(33, 0, 0, 0); idle(10);

    // R3: outcome with a wrong tag and an outcome for a non-load
    phase = "R3 stray outcome";
    issue(40, 1, 1, 0); issue(41, 0, 0, 0); idle(3);
    man_res = 1'b1; res_valid = 1'b1; res_tag = 6'd7; res_hit = 1'b0; tick();
    man_res = 1'b1; res_valid = 1'b1; res_tag = 6'd41; res_hit = 1'b0; tick();
    idle(6);

    // R9: reset drops record, pending fills and outcomes from before
    phase = "R9 reset clears";
    auto_fill = 1'b0; auto_res = 1'b1;
    issue(50, 1, 0, 0); idle(6);
    auto_res = 1'b0;
    issue(51, 1, 1, 0); issue(52, 0, 0, 0);
    rst = 1'b1; tick(); rst = 1'b0;
    idle(1);
    man_res = 1'b1; res_valid = 1'b1; res_tag = 6'd51; res_hit = 1'b0; tick();
    man_fill = 1'b1; fill_valid = 1'b1; fill_tag = 6'd50; tick();
    idle(4);
    auto_res = 1'b1; auto_fill = 1'b1;

    // Mixed traffic, all requirements against the model
    phase = "R2 R5 R6 R7 R10 mixed";
    tg = 0;
    for (int k = 0; k < 2000; k++) begin
      if (k % 300 == 299) spec_off = ~spec_off;
      if ($urandom % 25 == 0) begin
        man_res = 1'b1; res_valid = 1'b1;
        res_tag = 6'($urandom); res_hit = 1'b0;
      end
      if ($urandom % 8 < 6) begin
        issue(tg, ($urandom % 3) == 0, ($urandom % 4) != 0, $urandom % 2);
        tg = (tg + 1) % 64;
      end else begin
        tick();
      end
    end
    idle(12);
    finish_run();
  end
endmodule